// File: doc/BRIEF.md
# CAM Result-Address Bus Controller

This block manages the result-address output of one device in a cascade of content-addressable memories. Each access cycle is presented with an active-low enable strobe and a three-bit cycle code. When the strobe falls, the block decides what the cycle means for the result address. The candidate value can come from the accessed address, from the compare array's match address, from the next-free address, or from the stored match address. A cycle can also leave the value as it is. The block also sets the drive eligibility that the cycle leaves behind.

The visible address, the local match flags and the full flag are refreshed only on clock edges where the strobe is high. They freeze while the strobe is low. The output enable gates the bus without any clock, combined with the eligibility left by the last cycle. A 32-bit status word mirrors the visible address and the local flags. A steering output decides whether this device answers a status read.

Top module: `cam_rab_ctrl`

## Requirements
- R1: A random read (code 0) or random write (code 1) with `cs_n` low loads `acc_addr` into `ra_val`. Afterwards `ra_oe` is 1 whenever `oe_n` is 0.
- R2: A random read or write with `cs_n` high leaves `ra_val` unchanged. It forces `ra_oe` to 0 and `ra_bus` to high impedance whatever `oe_n` is.
- R3: A broadcast write (code 2) loads `acc_addr` whatever `cs_n` is. Afterwards `ra_oe` follows `oe_n` low.
- R4: A register write (code 4) or status read (code 5) changes neither `ra_val` nor the drive eligibility.
- R5: A cycle is taken on the first clock edge where `en_n` is low after being high. Its results appear on the first later edge where `en_n` is high. `ra_val`, `match_flag` and `multi_flag` hold while `en_n` is low.
- R6: `oe_n` high gives `ra_oe` 0 and a high-impedance `ra_bus`. `ra_oe` follows `oe_n` without waiting for a clock.
- R7: A compare (code 3) sets `match_flag` to `cmp_hit` and `multi_flag` to `cmp_hit & cmp_multi`. It loads `cmp_addr`, and the bus is eligible only on a hit.
- R8: The match flags keep the last compare result through other cycles. A highest-priority-match read (code 7) restores the stored compare address, with eligibility equal to the stored hit.
- R9: A write at next free (code 6) loads `nf_addr`, and the bus is eligible only if `full_in` was 0 when the cycle was taken.
- R10: The status word is laid out as follows, and `up_match` and `up_full` never affect it:
  - bits 15:0 equal `ra_val`;
  - bit 16 is `match_flag`;
  - bit 17 is `multi_flag`;
  - bit 18 is the local full flag;
  - all other bits are 0.

  The cascade outputs are `chain_match = match_flag | up_match` and `chain_full = full & up_full`.
- R11: During a status read, `stat_oe` is 1 only while `en_n` is low.
  - If the last address-changing cycle was a random or broadcast access, the device answers when `cs_n` is low.
  - Otherwise it answers only when its bus is eligible.
- R12: Reset clears `ra_val`, the flags and the eligibility, so `ra_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low cycle strobe |
| oe_n | input | 1 | Active-low result-bus output enable |
| cs_n | input | 1 | Active-low chip select |
| cyc | input | 3 | Cycle code |
| acc_addr | input | ADDR_W | Address of a random or broadcast access |
| cmp_hit | input | 1 | Compare array reports a match |
| cmp_multi | input | 1 | Compare array reports more than one match |
| cmp_addr | input | ADDR_W | Highest-priority match address |
| nf_addr | input | ADDR_W | Next free address |
| full_in | input | 1 | Array has no free entry |
| up_match | input | 1 | Match indication from the upstream device |
| up_full | input | 1 | Full indication from the upstream device |
| ra_bus | output | ADDR_W | Tri-state result-address bus |
| ra_oe | output | 1 | Bus is being driven |
| ra_val | output | ADDR_W | Held result address |
| match_flag | output | 1 | Local match from the last compare |
| multi_flag | output | 1 | Local multiple match from the last compare |
| chain_match | output | 1 | Cascaded match |
| chain_full | output | 1 | Cascaded full |
| status_word | output | 32 | Status mirror of bus and local flags |
| stat_oe | output | 1 | This device answers the current status read |

## Verification
The assertions check, on every cycle:
- the freeze of address and flags while the strobe is low;
- the gating of `ra_oe` by `oe_n`;
- the dependency of the multiple-match flag on the match flag;
- the status-word mirror;
- the status-read steering window;
- the reset values.

Only the directed scenarios can show which value each cycle code loads and that register writes leave the value in place. The same holds for the refusal to drive after a random access to an unselected device, and for the restoration of the match address by a later match-address read.

// File: rtl/cam_rab_pkg.sv
package cam_rab_pkg;

    typedef enum logic [2:0] {
        CYC_RD_RAND  = 3'd0,
        CYC_WR_RAND  = 3'd1,
        CYC_WR_BCAST = 3'd2,
        CYC_CMP      = 3'd3,
        CYC_WR_REG   = 3'd4,
        CYC_RD_STAT  = 3'd5,
        CYC_WR_NF    = 3'd6,
        CYC_RD_HPM   = 3'd7
    } cyc_e;

    typedef struct packed {
        logic elig;       // bus may be driven when output enable is low
        logic rand_last;  // last address cycle was random or broadcast
        logic hit;        // local match
        logic multi;      // local multiple match
    } rab_flags_t;

    localparam int STAT_W     = 32;
    localparam int STAT_MIRW  = 16;
    localparam int STAT_HIT   = 16;
    localparam int STAT_MULTI = 17;
    localparam int STAT_FULL  = 18;

    function automatic logic is_random(input cyc_e c);
        return (c == CYC_RD_RAND) || (c == CYC_WR_RAND);
    endfunction

endpackage

// File: rtl/rab_capture.sv
module rab_capture
    import cam_rab_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              cs_n,
    input  logic [2:0]        cyc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              cmp_hit,
    input  logic              cmp_multi,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] nf_addr,
    input  logic              full_in,
    output logic [ADDR_W-1:0] pend_addr,
    output rab_flags_t        pend_flg
);
    logic              en_q;
    logic              cap;
    logic [ADDR_W-1:0] match_addr_q;
    cyc_e              code;

    assign code = cyc_e'(cyc);
    assign cap  = !en_n && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q         <= 1'b1;
            pend_addr    <= '0;
            pend_flg     <= '0;
            match_addr_q <= '0;
        end else begin
            en_q <= en_n;
            if (cap) begin
                if (is_random(code)) begin
                    pend_flg.rand_last <= 1'b1;
                    pend_flg.elig      <= !cs_n;
                    if (!cs_n) pend_addr <= acc_addr;
                end else begin
                    case (code)
                        CYC_WR_BCAST: begin
                            pend_addr          <= acc_addr;
                            pend_flg.elig      <= 1'b1;
                            pend_flg.rand_last <= 1'b1;
                        end
                        CYC_CMP: begin
                            pend_addr          <= cmp_addr;
                            match_addr_q       <= cmp_addr;
                            pend_flg.hit       <= cmp_hit;
                            pend_flg.multi     <= cmp_hit & cmp_multi;
                            pend_flg.elig      <= cmp_hit;
                            pend_flg.rand_last <= 1'b0;
                        end
                        CYC_WR_NF: begin
                            pend_addr          <= nf_addr;
                            pend_flg.elig      <= !full_in;
                            pend_flg.rand_last <= 1'b0;
                        end
                        CYC_RD_HPM: begin
                            pend_addr          <= match_addr_q;
                            pend_flg.elig      <= pend_flg.hit;
                            pend_flg.rand_last <= 1'b0;
                        end
                        default: ;  // register write, status read: no change
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/rab_hold.sv
module rab_hold
    import cam_rab_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] pend_addr,
    input  rab_flags_t        pend_flg,
    input  logic              full_in,
    output logic [ADDR_W-1:0] vis_addr,
    output rab_flags_t        vis_flg,
    output logic              vis_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vis_addr <= '0;
            vis_flg  <= '0;
            vis_full <= 1'b0;
        end else if (en_n) begin
            vis_addr <= pend_addr;
            vis_flg  <= pend_flg;
            vis_full <= full_in;
        end
    end
endmodule

// File: rtl/rab_drive.sv
module rab_drive
    import cam_rab_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              oe_n,
    input  logic              en_n,
    input  logic              cs_n,
    input  logic [2:0]        cyc,
    input  logic [ADDR_W-1:0] vis_addr,
    input  rab_flags_t        vis_flg,
    input  logic              vis_full,
    input  logic              up_match,
    input  logic              up_full,
    output logic [ADDR_W-1:0] ra_bus,
    output logic              ra_oe,
    output logic              chain_match,
    output logic              chain_full,
    output logic [STAT_W-1:0] status_word,
    output logic              stat_oe
);
    localparam int MIRW = (ADDR_W < STAT_MIRW) ? ADDR_W : STAT_MIRW;

    logic [STAT_MIRW-1:0] mirror;

    assign ra_oe  = !oe_n && vis_flg.elig;
    assign ra_bus = ra_oe ? vis_addr : {ADDR_W{1'bz}};

    generate
        if (ADDR_W < STAT_MIRW) begin : g_ext
            assign mirror = {{(STAT_MIRW-ADDR_W){1'b0}}, vis_addr};
        end else begin : g_cut
            assign mirror = vis_addr[MIRW-1:0];
        end
    endgenerate

    always_comb begin
        status_word                  = '0;
        status_word[STAT_MIRW-1:0]   = mirror;
        status_word[STAT_HIT]        = vis_flg.hit;
        status_word[STAT_MULTI]      = vis_flg.multi;
        status_word[STAT_FULL]       = vis_full;
    end

    assign chain_match = vis_flg.hit | up_match;
    assign chain_full  = vis_full & up_full;
    assign stat_oe     = (cyc_e'(cyc) == CYC_RD_STAT) && !en_n &&
                         (vis_flg.rand_last ? !cs_n : vis_flg.elig);
endmodule

// File: rtl/cam_rab_ctrl.sv
module cam_rab_ctrl
    import cam_rab_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              oe_n,
    input  logic              cs_n,
    input  logic [2:0]        cyc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              cmp_hit,
    input  logic              cmp_multi,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] nf_addr,
    input  logic              full_in,
    input  logic              up_match,
    input  logic              up_full,
    output logic [ADDR_W-1:0] ra_bus,
    output logic              ra_oe,
    output logic [ADDR_W-1:0] ra_val,
    output logic              match_flag,
    output logic              multi_flag,
    output logic              chain_match,
    output logic              chain_full,
    output logic [STAT_W-1:0] status_word,
    output logic              stat_oe
);
    logic [ADDR_W-1:0] pend_addr;
    rab_flags_t        pend_flg;
    logic [ADDR_W-1:0] vis_addr;
    rab_flags_t        vis_flg;
    logic              vis_full;

    rab_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst(rst), .en_n(en_n), .cs_n(cs_n), .cyc(cyc),
        .acc_addr(acc_addr), .cmp_hit(cmp_hit), .cmp_multi(cmp_multi),
        .cmp_addr(cmp_addr), .nf_addr(nf_addr), .full_in(full_in),
        .pend_addr(pend_addr), .pend_flg(pend_flg)
    );

    rab_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk(clk), .rst(rst), .en_n(en_n), .pend_addr(pend_addr),
        .pend_flg(pend_flg), .full_in(full_in),
        .vis_addr(vis_addr), .vis_flg(vis_flg), .vis_full(vis_full)
    );

    rab_drive #(.ADDR_W(ADDR_W)) u_drv (
        .oe_n(oe_n), .en_n(en_n), .cs_n(cs_n), .cyc(cyc),
        .vis_addr(vis_addr), .vis_flg(vis_flg), .vis_full(vis_full),
        .up_match(up_match), .up_full(up_full),
        .ra_bus(ra_bus), .ra_oe(ra_oe), .chain_match(chain_match),
        .chain_full(chain_full), .status_word(status_word), .stat_oe(stat_oe)
    );

    assign ra_val     = vis_addr;
    assign match_flag = vis_flg.hit;
    assign multi_flag = vis_flg.multi;
endmodule

// File: rtl/cam_rab_ctrl_chk.sv
module cam_rab_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en_n,
    input logic              oe_n,
    input logic [2:0]        cyc,
    input logic              ra_oe,
    input logic [ADDR_W-1:0] ra_val,
    input logic              match_flag,
    input logic              multi_flag,
    input logic [31:0]       status_word,
    input logic              stat_oe
);
    localparam int MW = (ADDR_W < 16) ? ADDR_W : 16;

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !en_n |=> ($stable(ra_val) && $stable(match_flag) && $stable(multi_flag)));

    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (rst)
        ra_oe |-> !oe_n);

    assert_multi_R7: assert property (@(posedge clk) disable iff (rst)
        multi_flag |-> match_flag);

    assert_status_R10: assert property (@(posedge clk) disable iff (rst)
        (status_word[MW-1:0] == ra_val[MW-1:0]) && (status_word[16] == match_flag)
        && (status_word[17] == multi_flag) && (status_word[31:19] == '0));

    assert_statoe_R11: assert property (@(posedge clk) disable iff (rst)
        stat_oe |-> (!en_n && cyc == 3'd5));

    assert_reset_R12: assert property (@(posedge clk)
        $past(rst) |-> (ra_val == '0 && !match_flag && !ra_oe));
endmodule

bind cam_rab_ctrl cam_rab_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .en_n(en_n), .oe_n(oe_n), .cyc(cyc),
    .ra_oe(ra_oe), .ra_val(ra_val), .match_flag(match_flag),
    .multi_flag(multi_flag), .status_word(status_word), .stat_oe(stat_oe)
);

// File: tb/cam_rab_ctrl_bench.sv
`timescale 1ns/1ps
module cam_rab_ctrl_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_n = 1'b1, oe_n = 1'b0, cs_n = 1'b1;
    logic [2:0]    cyc = 3'd4;
    logic [AW-1:0] acc_addr = '0, cmp_addr = '0, nf_addr = '0;
    logic          cmp_hit = 1'b0, cmp_multi = 1'b0, full_in = 1'b0;
    logic          up_match = 1'b0, up_full = 1'b0;
    logic [AW-1:0] ra_bus, ra_val;
    logic          ra_oe, match_flag, multi_flag, chain_match, chain_full, stat_oe;
    logic [31:0]   status_word;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    cam_rab_ctrl #(.ADDR_W(AW)) u_cam_rab_ctrl (
        .clk(clk), .rst(rst), .en_n(en_n), .oe_n(oe_n), .cs_n(cs_n), .cyc(cyc),
        .acc_addr(acc_addr), .cmp_hit(cmp_hit), .cmp_multi(cmp_multi),
        .cmp_addr(cmp_addr), .nf_addr(nf_addr), .full_in(full_in),
        .up_match(up_match), .up_full(up_full), .ra_bus(ra_bus), .ra_oe(ra_oe),
        .ra_val(ra_val), .match_flag(match_flag), .multi_flag(multi_flag),
        .chain_match(chain_match), .chain_full(chain_full),
        .status_word(status_word), .stat_oe(stat_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full cycle: taken at the first edge, results visible after release
    task automatic run_cycle(input logic [2:0] code, input logic [AW-1:0] a, input logic csn);
        @(negedge clk);
        en_n = 1'b0; cyc = code; acc_addr = a; cs_n = csn;
        @(negedge clk);
        en_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 addr", ra_val, 0);
        check("R12 flags", {match_flag, multi_flag}, 0);
        check("R12 oe", ra_oe, 0);
        check("R12 status", status_word, 0);
    endtask

    task automatic t_rand_sel;
        run_cycle(3'd0, 16'h1234, 1'b0);
        check("R1 read val", ra_val, 16'h1234);
        check("R1 read oe", ra_oe, 1);
        check("R1 bus", ra_bus, 16'h1234);
        run_cycle(3'd1, 16'h00AB, 1'b0);
        check("R1 write val", ra_val, 16'h00AB);
    endtask

    task automatic t_rand_unsel;
        run_cycle(3'd0, 16'h5555, 1'b1);
        check("R2 val kept", ra_val, 16'h00AB);
        check("R2 oe", ra_oe, 0);
        check("R2 bus z", ra_bus, 16'hzzzz);
        run_cycle(3'd1, 16'h6666, 1'b1);
        check("R2 write val kept", ra_val, 16'h00AB);
    endtask

    task automatic t_bcast;
        run_cycle(3'd2, 16'h0F0F, 1'b1);
        check("R3 val", ra_val, 16'h0F0F);
        check("R3 oe", ra_oe, 1);
    endtask

    task automatic t_reg;
        run_cycle(3'd4, 16'h7777, 1'b0);
        check("R4 regwr val", ra_val, 16'h0F0F);
        check("R4 regwr oe", ra_oe, 1);
        run_cycle(3'd5, 16'h8888, 1'b0);
        check("R4 statrd val", ra_val, 16'h0F0F);
        check("R4 statrd oe", ra_oe, 1);
    endtask

    task automatic t_oe;
        @(negedge clk);
        oe_n = 1'b1; #0.5;
        check("R6 oe off", ra_oe, 0);
        check("R6 bus z", ra_bus, 16'hzzzz);
        oe_n = 1'b0; #0.5;
        check("R6 oe on async", ra_oe, 1);
    endtask

    task automatic t_cmp;
        cmp_hit = 1'b1; cmp_multi = 1'b1; cmp_addr = 16'h0042;
        run_cycle(3'd3, 16'h0000, 1'b1);
        check("R7 hit flags", {match_flag, multi_flag}, 2'b11);
        check("R7 hit val", ra_val, 16'h0042);
        check("R7 hit oe", ra_oe, 1);
        cmp_hit = 1'b0; cmp_multi = 1'b1; cmp_addr = 16'h0099;
        run_cycle(3'd3, 16'h0000, 1'b1);
        check("R7 miss flags", {match_flag, multi_flag}, 2'b00);
        check("R7 miss val", ra_val, 16'h0099);
        check("R7 miss oe", ra_oe, 0);
    endtask

    task automatic t_hold;
        cmp_hit = 1'b1; cmp_multi = 1'b0; cmp_addr = 16'h0033;
        @(negedge clk);
        en_n = 1'b0; cyc = 3'd3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 held val", ra_val, 16'h0099);
            check("R5 held flag", match_flag, 0);
        end
        en_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R5 released val", ra_val, 16'h0033);
        check("R5 released flag", match_flag, 1);
    endtask

    task automatic t_hpm;
        cmp_hit = 1'b0; cmp_addr = 16'h0ABC;
        run_cycle(3'd1, 16'h2222, 1'b0);
        check("R8 other addr", ra_val, 16'h2222);
        check("R8 flag kept", match_flag, 1);
        run_cycle(3'd7, 16'h0000, 1'b1);
        check("R8 restored", ra_val, 16'h0033);
        check("R8 oe", ra_oe, 1);
    endtask

    task automatic t_nf;
        full_in = 1'b0; nf_addr = 16'h0400;
        run_cycle(3'd6, 16'h0000, 1'b1);
        check("R9 val", ra_val, 16'h0400);
        check("R9 oe", ra_oe, 1);
        full_in = 1'b1; nf_addr = 16'h0500;
        run_cycle(3'd6, 16'h0000, 1'b1);
        check("R9 full val", ra_val, 16'h0500);
        check("R9 full oe", ra_oe, 0);
    endtask

    task automatic t_status;
        @(negedge clk);
        up_match = 1'b1; up_full = 1'b1; #0.5;
        check("R10 word", status_word, 32'h0005_0500);
        check("R10 chain", {chain_match, chain_full}, 2'b11);
        up_full = 1'b0; #0.5;
        check("R10 chain full", chain_full, 0);
        check("R10 full bit", status_word[18], 1);
        cmp_hit = 1'b0; cmp_addr = 16'h0011;
        run_cycle(3'd3, 16'h0000, 1'b1);
        check("R10 local miss", {status_word[16], match_flag, chain_match}, 3'b001);
        up_match = 1'b0; full_in = 1'b0;
    endtask

    task automatic stat_read(input logic csn, input logic exp, input string req);
        @(negedge clk);
        en_n = 1'b0; cyc = 3'd5; cs_n = csn; #0.5;
        check(req, stat_oe, exp);
        @(negedge clk);
        en_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_steer;
        stat_read(1'b0, 1'b0, "R11 miss selected");
        cmp_hit = 1'b1; cmp_addr = 16'h0077;
        run_cycle(3'd3, 16'h0000, 1'b1);
        stat_read(1'b1, 1'b1, "R11 hit owner");
        run_cycle(3'd0, 16'h0123, 1'b1);
        stat_read(1'b1, 1'b0, "R11 random unselected");
        stat_read(1'b0, 1'b1, "R11 random selected");
        check("R11 idle", stat_oe, 0);
    endtask

    initial begin
        #(4 * 20000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rand_sel();
        t_rand_unsel();
        t_bcast();
        t_reg();
        t_oe();
        t_cmp();
        t_hold();
        t_hpm();
        t_nf();
        t_status();
        t_steer();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule